// File: doc/BRIEF.md
# Configuration Stream DMA Command Launcher

This block takes a single transfer command written through a small register port, reads the source words from a memory read port and forwards them, in order, to a configuration sink over a valid/ready stream. When the command is finished it raises a one-cycle done event. Software programs four registers in sequence: source address, destination address, source length, destination length. The destination-length write launches the command using the values staged so far.

Bit 0 of the source address is not part of the address. It selects whether completion waits for the configuration sink to drain the final word, or is reported as soon as the final memory request has been accepted. An all-ones destination, or a destination length of zero, means the command has no write-back. Lengths count 32-bit words. A command is refused with an error event if one is already running, if it asks for a write-back, or if the fabric already reports that configuration is complete.

Read responses land in a small buffer. Memory requests are only issued while the words already requested plus the words buffered leave room, so the response port needs no back-pressure.

Top module: `cfg_dma_launcher`

## Requirements
- R1: After reset, busy is 0, mem_req_valid is 0, cfg_valid is 0 and evt_vec is all zeros.
- R2: reg_wr_sel selects the register written: 0 source address, 1 destination address, 2 source length, 3 destination length. A write with select 3 launches a command from the staged source address, destination address and source length, with the written value as destination length.
- R3: Fetch addresses start at the source address with bits 1:0 cleared and rise by 4 per word. Exactly as many requests are made as the source length, and only the low 27 bits of the source length are used (maximum 0x7FFFFFF).
- R4: The words are presented on cfg_data in fetch order. While cfg_valid is high and cfg_ready is low, cfg_data holds, and no word is lost or repeated.
- R5: While mem_req_valid is high and mem_req_ready is low, the request stays valid and mem_req_addr holds.
- R6: Completion is a one-cycle pulse on evt_vec bit 13. With source-address bit 0 clear it may come before the sink has taken the words. With bit 0 set it comes only after the last word has been taken, and cfg_valid is 0 in the pulse cycle.
- R7: A launch with source length 0 sets evt_vec bit 13 in the cycle after the launching write and issues no memory request.
- R8: A launch while busy sets evt_vec bit 15 in the cycle after the write. The running transfer continues and completes with all its words.
- R9: A launch while fabric_done is high sets evt_vec bit 14 in the cycle after the write, issues no request and gives no done pulse.
- R10: A launch whose destination is not 0xFFFFFFFF and whose destination length is nonzero sets evt_vec bit 15 and transfers nothing. With destination length 0, the launch proceeds whatever the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select (R2) |
| reg_wr_data | input | 32 | Register write value |
| fabric_done | input | 1 | Fabric reports configuration complete |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word requested |
| mem_rsp_valid | input | 1 | Read data valid, one per accepted request, in order |
| mem_rsp_data | input | DATA_W | Read data |
| cfg_valid | output | 1 | Stream word valid |
| cfg_ready | input | 1 | Sink accepts the word |
| cfg_data | output | DATA_W | Stream word |
| busy | output | 1 | A command is running |
| evt_vec | output | 32 | Event pulses: bit 13 done, bit 14 refused because configuration is complete, bit 15 command error |

## Verification
Refusals and zero-length completions are registered from the launching write, so they appear exactly one cycle later. The bench reads evt_vec at the falling edge that follows that write's rising edge. Normal completions and stream words depend on memory and sink stall patterns, so the bench logs every handshake and event with its cycle number. It then compares order, counts and the cycle of the done pulse against the cycle of the last accepted word, waiting out a bounded window before it checks the totals. Handshakes are decided at the falling edge: the ready value set there, together with outputs that are stable until the next rising edge, defines the transfer at that edge.

// File: rtl/cdl_pkg.sv
package cdl_pkg;

  localparam logic [31:0] NO_DEST = 32'hFFFF_FFFF;

  localparam int EVT_DONE    = 13;
  localparam int EVT_CFG_ERR = 14;
  localparam int EVT_CMD_ERR = 15;

  typedef enum logic [1:0] {
    SEL_SRC_ADDR = 2'd0,
    SEL_DST_ADDR = 2'd1,
    SEL_SRC_LEN  = 2'd2,
    SEL_DST_LEN  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    LAUNCH_OK,
    LAUNCH_BUSY,
    LAUNCH_CFG_DONE,
    LAUNCH_WRITEBACK
  } launch_e;

  function automatic logic [31:0] fetch_base(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction

  function automatic logic [31:0] next_word_addr(input logic [31:0] a);
    return a + 32'd4;
  endfunction

  function automatic logic wants_writeback(input logic [31:0] dst, input logic [31:0] dlen);
    return (dst != NO_DEST) && (dlen != 32'd0);
  endfunction

  function automatic launch_e classify(input logic busy, input logic cfg_done,
                                       input logic wb);
    if (busy)          return LAUNCH_BUSY;
    else if (cfg_done) return LAUNCH_CFG_DONE;
    else if (wb)       return LAUNCH_WRITEBACK;
    else               return LAUNCH_OK;
  endfunction

endpackage

// File: rtl/cdl_cmd_regs.sv
module cdl_cmd_regs
  import cdl_pkg::*;
#(
  parameter int unsigned LEN_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  output logic [31:0]      stg_src,
  output logic [31:0]      stg_dst,
  output logic [LEN_W-1:0] stg_len,
  output logic             start_req
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_src <= '0;
      stg_dst <= NO_DEST;
      stg_len <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_SRC_ADDR: stg_src <= wr_data;
        SEL_DST_ADDR: stg_dst <= wr_data;
        SEL_SRC_LEN:  stg_len <= wr_data[LEN_W-1:0];
        default:      ;
      endcase
    end
  end

  assign start_req = wr_en && (sel == SEL_DST_LEN);

endmodule

// File: rtl/cdl_fetch.sv
module cdl_fetch
  import cdl_pkg::*;
#(
  parameter int unsigned LEN_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [31:0]      load_base,
  input  logic [LEN_W-1:0] load_words,
  input  logic             active,
  input  logic             credit_ok,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [31:0]      req_addr,
  output logic             req_fire,
  output logic             all_issued
);

  logic [31:0]      addr_q;
  logic [LEN_W-1:0] left_q;

  assign all_issued = (left_q == '0);
  assign req_valid  = active && !all_issued && credit_ok;
  assign req_fire   = req_valid && req_ready;
  assign req_addr   = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (load) begin
      addr_q <= load_base;
      left_q <= load_words;
    end else if (req_fire) begin
      addr_q <= next_word_addr(addr_q);
      left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/cdl_fifo.sv
module cdl_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              do_pop;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign out_valid = (count != '0);
  assign out_data  = store[rd_ptr];
  assign do_pop    = pop && out_valid;

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= wrap_inc(wr_ptr);
      if (do_pop) rd_ptr <= wrap_inc(rd_ptr);
      case ({push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfg_dma_launcher.sv
module cfg_dma_launcher
  import cdl_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LEN_W      = 27,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [31:0]       reg_wr_data,
  input  logic              fabric_done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [DATA_W-1:0] cfg_data,
  output logic              busy,
  output logic [31:0]       evt_vec
);

  logic [31:0]      stg_src, stg_dst;
  logic [LEN_W-1:0] stg_len;
  logic             start_req;

  logic             busy_q, wait_q, done_q, cmd_err_q, cfg_err_q;
  logic [CNT_W-1:0] osd_q, fifo_cnt;
  logic             credit_ok, req_fire, all_issued;
  logic             launch_go, finish;
  launch_e          verdict;

  cdl_cmd_regs #(.LEN_W(LEN_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_sel    (reg_wr_sel),
    .wr_data   (reg_wr_data),
    .stg_src   (stg_src),
    .stg_dst   (stg_dst),
    .stg_len   (stg_len),
    .start_req (start_req)
  );

  assign verdict   = classify(busy_q, fabric_done, wants_writeback(stg_dst, reg_wr_data));
  assign launch_go = start_req && (verdict == LAUNCH_OK);

  // Requests in flight plus words held never exceed the buffer depth.
  assign credit_ok = ({1'b0, osd_q} + {1'b0, fifo_cnt}) < (CNT_W + 1)'(FIFO_DEPTH);

  cdl_fetch #(.LEN_W(LEN_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (launch_go),
    .load_base  (fetch_base(stg_src)),
    .load_words (stg_len),
    .active     (busy_q),
    .credit_ok  (credit_ok),
    .req_ready  (mem_req_ready),
    .req_valid  (mem_req_valid),
    .req_addr   (mem_req_addr),
    .req_fire   (req_fire),
    .all_issued (all_issued)
  );

  cdl_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (mem_rsp_valid),
    .push_data (mem_rsp_data),
    .pop       (cfg_ready),
    .out_valid (cfg_valid),
    .out_data  (cfg_data),
    .count     (fifo_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osd_q <= '0;
    end else begin
      case ({req_fire, mem_rsp_valid})
        2'b10:   osd_q <= osd_q + 1'b1;
        2'b01:   osd_q <= osd_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign finish = busy_q && all_issued &&
                  (!wait_q || ((osd_q == '0) && (fifo_cnt == '0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      wait_q    <= 1'b0;
      done_q    <= 1'b0;
      cmd_err_q <= 1'b0;
      cfg_err_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      cmd_err_q <= 1'b0;
      cfg_err_q <= 1'b0;
      if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
      if (start_req) begin
        case (verdict)
          LAUNCH_OK: begin
            wait_q <= stg_src[0];
            if (stg_len == '0) done_q <= 1'b1;
            else               busy_q <= 1'b1;
          end
          LAUNCH_CFG_DONE: cfg_err_q <= 1'b1;
          default:         cmd_err_q <= 1'b1;
        endcase
      end
    end
  end

  assign busy = busy_q;

  always_comb begin
    evt_vec              = '0;
    evt_vec[EVT_DONE]    = done_q;
    evt_vec[EVT_CFG_ERR] = cfg_err_q;
    evt_vec[EVT_CMD_ERR] = cmd_err_q;
  end

endmodule

// File: rtl/cdl_checker.sv
module cdl_checker #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              start_req,
  input logic              fabric_done,
  input logic              wait_q,
  input logic [CNT_W-1:0]  osd_q,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [31:0]       mem_req_addr,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic [DATA_W-1:0] cfg_data,
  input logic [31:0]       evt_vec
);

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(osd_q) + 32'(fifo_cnt)) <= DEPTH); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data))); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R5

  AST_WAIT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec[13] && wait_q) |-> !cfg_valid); // R6

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid); // R7

  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |=> evt_vec[15]); // R8

  AST_CFG_DONE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_req && fabric_done) |=> (!busy && evt_vec[14] && !evt_vec[13])); // R9

endmodule

bind cfg_dma_launcher cdl_checker #(
  .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy_q),
  .start_req     (start_req),
  .fabric_done   (fabric_done),
  .wait_q        (wait_q),
  .osd_q         (osd_q),
  .fifo_cnt      (fifo_cnt),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .cfg_valid     (cfg_valid),
  .cfg_ready     (cfg_ready),
  .cfg_data      (cfg_data),
  .evt_vec       (evt_vec)
);

// File: tb/sim_cfg_dma_launcher.sv
module sim_cfg_dma_launcher;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_sel = 2'd0;
  logic [31:0] reg_wr_data = '0;
  logic        fabric_done = 1'b0;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        cfg_valid, cfg_ready;
  logic [31:0] cfg_data;
  logic        busy;
  logic [31:0] evt_vec;

  always #10 clk = ~clk;

  cfg_dma_launcher u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .fabric_done(fabric_done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
    .busy(busy), .evt_vec(evt_vec)
  );

  int n_checks = 0;
  int n_fail   = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  function automatic logic ready_pat(input int mode, input int c);
    case (mode)
      0: return 1'b1;
      1: return c[0];
      2: return (c % 3) == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Environment: memory with 3-stage response latency, stream sink, event log.
  int          cyc = 0;
  int          mrdy_mode = 0, crdy_mode = 0;
  int          req_n = 0, addr_err = 0, cap_n = 0;
  int          done_n = 0, cfgerr_n = 0, cmderr_n = 0;
  int          done_cyc = 0, last_hs_cyc = 0;
  logic [31:0] exp_addr = '0;
  logic [31:0] cap [64];
  logic        pv [3];
  logic [31:0] pa [3];

  initial begin
    mem_req_ready = 1'b0;
    cfg_ready     = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pa[i] = '0; end
  end

  always @(negedge clk) begin
    logic acc;
    cyc++;
    if (rst_n) begin
      if (evt_vec[13]) begin done_n++; done_cyc = cyc; end
      if (evt_vec[14]) cfgerr_n++;
      if (evt_vec[15]) cmderr_n++;
    end
    mem_req_ready = ready_pat(mrdy_mode, cyc);
    acc = rst_n && mem_req_valid && mem_req_ready;
    if (acc) begin
      req_n++;
      if (mem_req_addr != exp_addr) addr_err++;
      exp_addr = exp_addr + 32'd4;
    end
    mem_rsp_valid = pv[0];
    mem_rsp_data  = mem_word(pa[0]);
    pv[0] = pv[1]; pa[0] = pa[1];
    pv[1] = pv[2]; pa[1] = pa[2];
    pv[2] = acc;   pa[2] = mem_req_addr;
    cfg_ready = ready_pat(crdy_mode, cyc);
    if (rst_n && cfg_valid && cfg_ready) begin
      if (cap_n < 64) cap[cap_n] = cfg_data;
      cap_n++;
      last_hs_cyc = cyc;
    end
  end

  task automatic clear_log(input logic [31:0] base, input int mm, input int cm);
    @(negedge clk); #1;
    req_n = 0; addr_err = 0; cap_n = 0; done_n = 0; cfgerr_n = 0; cmderr_n = 0;
    done_cyc = 0; last_hs_cyc = 0; exp_addr = base; mrdy_mode = mm; crdy_mode = cm;
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [31:0] data,
                           output logic [31:0] ev);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
    ev = evt_vec;
  endtask

  task automatic launch(input logic [31:0] src, input logic [31:0] dst,
                        input logic [31:0] len, input logic [31:0] dlen,
                        output logic [31:0] ev);
    logic [31:0] e;
    write_reg(2'd0, src, e);
    write_reg(2'd1, dst, e);
    write_reg(2'd2, len, e);
    write_reg(2'd3, dlen, ev);
  endtask

  task automatic wait_for(input int words, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (done_n >= 1 && cap_n >= words) break;
      @(negedge clk);
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic check_stream(input logic [31:0] base, input int n, input string req);
    int bad;
    bad = 0;
    check(cap_n == n, req, cap_n, n);
    for (int i = 0; i < n && i < 64; i++)
      if (cap[i] !== mem_word(base + 32'(4 * i))) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] len;
    logic [1:0]  mrdy;
    logic [1:0]  crdy;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{src: 32'h0000_1000, len: 32'd5,          mrdy: 2'd0, crdy: 2'd0},
    '{src: 32'h0000_2001, len: 32'd8,          mrdy: 2'd1, crdy: 2'd2},
    '{src: 32'h0000_3002, len: 32'hF800_0003,  mrdy: 2'd2, crdy: 2'd1},
    '{src: 32'h0000_4003, len: 32'd12,         mrdy: 2'd0, crdy: 2'd1},
    '{src: 32'h0000_5000, len: 32'd1,          mrdy: 2'd2, crdy: 2'd2}
  };

  initial begin
    #3_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] ev;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0 && mem_req_valid == 1'b0 && cfg_valid == 1'b0, "R1 idle outputs",
          {busy, mem_req_valid, cfg_valid}, 0);
    check(evt_vec == 32'd0, "R1 evt_vec", evt_vec, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table of commands: R2 register order, R3 addressing, R4 stream, R6 completion
    for (int v = 0; v < 5; v++) begin
      logic [31:0] base;
      int n;
      base = {VECS[v].src[31:2], 2'b00};
      n    = int'(VECS[v].len[26:0]);
      clear_log(base, int'(VECS[v].mrdy), int'(VECS[v].crdy));
      launch(VECS[v].src, 32'hFFFF_FFFF, VECS[v].len, 32'd0, ev);
      wait_for(n, 3000);
      check(done_n == 1, "R6 single done pulse", done_n, 1);
      check(req_n == n && addr_err == 0, "R3 fetch count and addresses", req_n, n);
      check_stream(base, n, "R2 R4 stream words");
      if (VECS[v].src[0])
        check(done_cyc > last_hs_cyc, "R6 done after drain", done_cyc, last_hs_cyc + 1);
    end

    // R6: without the wait flag, done may precede the sink taking any word
    clear_log(32'h0000_6000, 0, 3);
    launch(32'h0000_6000, 32'hFFFF_FFFF, 32'd3, 32'd0, ev);
    repeat (40) @(negedge clk);
    check(done_n == 1 && cap_n == 0, "R6 early done", {done_n[15:0], cap_n[15:0]}, 32'h0001_0000);
    crdy_mode = 0;
    repeat (20) @(negedge clk);
    check_stream(32'h0000_6000, 3, "R4 stalled words released");

    // R7: zero length
    clear_log(32'h0000_7000, 0, 0);
    launch(32'h0000_7000, 32'hFFFF_FFFF, 32'd0, 32'd0, ev);
    check(ev[13] == 1'b1, "R7 done one cycle after launch", ev, 32'h2000);
    repeat (10) @(negedge clk);
    check(req_n == 0 && done_n == 1 && busy == 1'b0, "R7 no requests", req_n, 0);

    // R8: launch while busy
    clear_log(32'h0000_8000, 0, 2);
    launch(32'h0000_8000, 32'hFFFF_FFFF, 32'd10, 32'd0, ev);
    repeat (4) @(negedge clk);
    write_reg(2'd3, 32'd0, ev);
    check(ev[15] == 1'b1, "R8 busy launch flagged", ev, 32'h8000);
    wait_for(10, 3000);
    check(done_n == 1 && cmderr_n == 1, "R8 one done one error", done_n, 1);
    check_stream(32'h0000_8000, 10, "R8 running transfer intact");

    // R9: fabric already configured
    clear_log(32'h0000_9000, 0, 0);
    fabric_done = 1'b1;
    launch(32'h0000_9000, 32'hFFFF_FFFF, 32'd4, 32'd0, ev);
    check(ev[14] == 1'b1 && ev[13] == 1'b0, "R9 refused", ev, 32'h4000);
    repeat (30) @(negedge clk);
    check(req_n == 0 && done_n == 0 && busy == 1'b0, "R9 nothing transferred", req_n, 0);
    fabric_done = 1'b0;

    // R10: write-back requested
    clear_log(32'h0000_A000, 0, 0);
    launch(32'h0000_A000, 32'h0000_8000, 32'd4, 32'd4, ev);
    check(ev[15] == 1'b1, "R10 write-back refused", ev, 32'h8000);
    repeat (30) @(negedge clk);
    check(req_n == 0 && done_n == 0, "R10 nothing transferred", req_n, 0);
    clear_log(32'h0000_B000, 0, 0);
    launch(32'h0000_B000, 32'h0000_8000, 32'd2, 32'd0, ev);
    wait_for(2, 2000);
    check(done_n == 1 && cmderr_n == 0, "R10 zero dst length runs", done_n, 1);
    check_stream(32'h0000_B000, 2, "R10 stream");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule